// File: doc/BRIEF.md
# Per-Layer Video Stream Gate

This block sits on the path from one foreground layer's packetised video input to the compositor. Both sides use a valid/ready handshake, and each beat carries start-of-packet and end-of-packet flags. A two-bit activation mode sets how each packet is handled. A packet can be held back, which leaves the upstream source stalled. It can be passed through unchanged, so the layer is shown. In drain mode its video beats are pulled in and discarded, so the layer is hidden, while packets of every other type still go downstream.

The packet type sits in the low four bits of a packet's first beat. Type 0 marks video data. Every other code, including 15 for control packets, marks a non-video packet. The disposition is chosen when a packet's first beat reaches the head of a small input buffer, and it holds until that packet's last beat. A mode change that lands inside a packet therefore takes effect from the next packet. The input buffer lets the block accept a few beats even while the layer is held. The output is registered, so the downstream ready signal has no combinational path to the upstream ready signal.

Top module: `vid_layer_gate`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: In mode 0 or mode 3, a packet whose first beat is at the buffer head is not drawn. The input accepts exactly SKID_DEPTH beats (4 by default) and then holds `in_ready` low, and no output beat appears.
- R3: In mode 1, every packet is forwarded in order. Data, start flag and end flag of each beat are unchanged, and every output packet begins with a start flag and carries no start flag after its first beat.
- R4: In mode 2, every beat of a video packet (type code 0 in bits 3:0 of the first beat) is accepted and dropped, and no output beat results.
- R5: In mode 2, packets with a type code from 1 to 15 in bits 3:0 of the first beat are forwarded exactly as in mode 1.
- R6: A video packet's disposition comes from the mode present when its first beat leaves the buffer, and a mode change during that packet does not alter it. The next packet uses the new mode.
- R7: A non-video packet that has started forwarding finishes forwarding even if the mode switches to 0 before its last beat.
- R8: Beats that arrive outside a packet (no start flag seen since the last end flag) are consumed and discarded, and the packet after them passes normally.
- R9: While `out_valid` is high and `out_ready` is low, the output beat stays valid and unchanged, and no beat is lost or repeated under any backpressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Activation mode: 0 hold, 1 show, 2 drain, 3 hold |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_data | input | DATA_W | Input beat payload; bits 3:0 of a first beat give the packet type |
| in_sop | input | 1 | Input first beat of packet |
| in_eop | input | 1 | Input last beat of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | DATA_W | Output beat payload |
| out_sop | output | 1 | Output first beat of packet |
| out_eop | output | 1 | Output last beat of packet |

## Verification
Two events can coincide here: a mode change, and the per-packet decision at the buffer head, which may fall in the same cycle or while that packet's later beats are still in flight. The bench provokes this by switching the mode a fixed number of beats into a packet, with the output always ready, so the first beat has already been decided. It then sends a second packet that must follow the new mode. Each case is judged by comparing the complete output stream beat by beat against a scoreboard. The scoreboard is filled from the mode each packet is expected to have taken.

// File: rtl/vlg_pkg.sv
package vlg_pkg;

  localparam int unsigned TYPE_W = 4;
  localparam logic [TYPE_W-1:0] PKT_VIDEO = 4'd0;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_SHOW  = 2'd1,
    MODE_DRAIN = 2'd2,
    MODE_RSVD  = 2'd3
  } gate_mode_e;

  typedef enum logic [1:0] {
    DISP_STALL = 2'd0,
    DISP_FWD   = 2'd1,
    DISP_DROP  = 2'd2
  } disp_e;

endpackage

// File: rtl/vlg_skid_fifo.sv
module vlg_skid_fifo #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem[rd_q];

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    cnt_en = push_i | pop_i;
    if (push_i) wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R4
  AST_FIFO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R2

endmodule

// File: rtl/vlg_pkt_router.sv
module vlg_pkt_router
  import vlg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              head_valid_i,
  input  logic [TYPE_W-1:0] head_type_i,
  input  logic              head_sop_i,
  input  logic              head_eop_i,
  input  logic              out_room_i,
  output logic              pop_o,
  output logic              load_o
);

  logic  in_pkt_q, in_pkt_d;
  disp_e disp_q, disp_d, disp_now;
  logic  st_en;

  always_comb begin
    if (in_pkt_q) begin
      disp_now = disp_q;
    end else if (!head_sop_i) begin
      disp_now = DISP_DROP;
    end else begin
      case (gate_mode_e'(mode_i))
        MODE_SHOW:  disp_now = DISP_FWD;
        MODE_DRAIN: disp_now = (head_type_i == PKT_VIDEO) ? DISP_DROP : DISP_FWD;
        default:    disp_now = DISP_STALL;
      endcase
    end
  end

  assign pop_o  = head_valid_i &
                  ((disp_now == DISP_DROP) | ((disp_now == DISP_FWD) & out_room_i));
  assign load_o = pop_o & (disp_now == DISP_FWD);

  always_comb begin
    st_en    = pop_o;
    in_pkt_d = in_pkt_q ? !head_eop_i : (head_sop_i & !head_eop_i);
    disp_d   = (!in_pkt_q && head_sop_i) ? disp_now : disp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      disp_q   <= DISP_FWD;
    end else if (st_en) begin
      in_pkt_q <= in_pkt_d;
      disp_q   <= disp_d;
    end
  end

  AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pkt_q && head_valid_i && head_sop_i &&
     (mode_i == MODE_HOLD || mode_i == MODE_RSVD)) |-> !pop_o); // R2
  AST_DRAIN_VIDEO_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pkt_q && head_valid_i && head_sop_i && mode_i == MODE_DRAIN &&
     head_type_i == PKT_VIDEO) |-> (pop_o && !load_o)); // R4
  AST_DISP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && !(pop_o && head_eop_i)) |=> (in_pkt_q && disp_q == $past(disp_q))); // R6
  AST_MID_PKT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && head_valid_i && out_room_i) |-> pop_o); // R7

endmodule

// File: rtl/vlg_out_stage.sv
module vlg_out_stage #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic         room_o,
  input  logic         out_ready_i,
  output logic         out_valid_o,
  output logic [W-1:0] dout_o
);

  logic         valid_q, valid_d;
  logic [W-1:0] data_q;

  assign room_o      = !valid_q | out_ready_i;
  assign out_valid_o = valid_q;
  assign dout_o      = data_q;

  always_comb begin
    if (load_i)           valid_d = 1'b1;
    else if (out_ready_i) valid_d = 1'b0;
    else                  valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= din_i;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(dout_o))); // R9
  AST_LOAD_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> room_o); // R9

endmodule

// File: rtl/vid_layer_gate.sv
module vid_layer_gate
  import vlg_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SKID_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  localparam int unsigned BEAT_W = DATA_W + 2;

  logic              fifo_full, fifo_empty, push, pop, load, room;
  logic [BEAT_W-1:0] head_beat, out_beat;

  assign in_ready = !fifo_full;
  assign push     = in_valid & in_ready;

  vlg_skid_fifo #(.W(BEAT_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .din_i   ({in_sop, in_eop, in_data}),
    .full_o  (fifo_full),
    .pop_i   (pop),
    .dout_o  (head_beat),
    .empty_o (fifo_empty)
  );

  vlg_pkt_router u_router (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .head_valid_i (!fifo_empty),
    .head_type_i  (head_beat[TYPE_W-1:0]),
    .head_sop_i   (head_beat[BEAT_W-1]),
    .head_eop_i   (head_beat[BEAT_W-2]),
    .out_room_i   (room),
    .pop_o        (pop),
    .load_o       (load)
  );

  vlg_out_stage #(.W(BEAT_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .din_i       (head_beat),
    .room_o      (room),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .dout_o      (out_beat)
  );

  assign out_sop  = out_beat[BEAT_W-1];
  assign out_eop  = out_beat[BEAT_W-2];
  assign out_data = out_beat[DATA_W-1:0];

  logic out_mid_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      out_mid_q <= 1'b0;
    else if (out_valid && out_ready) out_mid_q <= !out_eop;
  end

  AST_OUT_SOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mid_q) |-> out_sop); // R3
  AST_OUT_NO_SOP_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mid_q) |-> !out_sop); // R3

endmodule

// File: tb/vid_layer_gate_test.sv
`timescale 1ns/1ps
module vid_layer_gate_test;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          in_valid, in_ready, in_sop, in_eop;
  logic [DW-1:0] in_data;
  logic          out_valid, out_ready, out_sop, out_eop;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int pat = 0;
  int cyc = 0;
  int wd = 0;
  logic [7:0] pkt_id = 8'd0;
  logic [DW+1:0] exp_q[$];
  logic [DW+1:0] got_q[$];
  logic          pend;
  logic [DW+1:0] pend_beat;

  always #2 clk = ~clk;

  vid_layer_gate #(.DATA_W(DW), .SKID_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // output side: ready pattern, capture, backpressure stability (R9)
  always @(negedge clk) begin
    logic r;
    if (!rst_n) begin
      out_ready = 1'b0;
      pend = 1'b0;
    end else begin
      cyc++;
      case (pat)
        0:       r = 1'b1;
        1:       r = cyc[0];
        default: r = ((cyc % 3) != 0);
      endcase
      if (pend) begin
        check("R9 valid held", {31'd0, out_valid}, 32'd1);
        check("R9 beat held", {14'd0, out_sop, out_eop, out_data}, {14'd0, pend_beat});
      end
      if (out_valid && r) got_q.push_back({out_sop, out_eop, out_data});
      pend = out_valid && !r;
      pend_beat = {out_sop, out_eop, out_data};
      out_ready = r;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL R-all watchdog: cycles=%0d expected below 150000", wd);
      summary();
      $finish;
    end
  end

  task automatic send_pkt(input logic [3:0] typ, input int len, input int first,
                          input bit fwd, input int chg_at, input logic [1:0] chg_mode,
                          input int tmo, output int taken);
    taken = 0;
    for (int k = first; k < len; k++) begin
      int w;
      @(negedge clk);
      if (k == chg_at) mode = chg_mode;
      in_valid = 1'b1;
      in_sop   = (k == 0);
      in_eop   = (k == len - 1);
      in_data  = (k == 0) ? {pkt_id, 4'(k), typ} : {pkt_id, 4'(k), 4'(k + 5)};
      w = 0;
      while (!in_ready) begin
        if (w >= tmo) begin
          in_valid = 1'b0;
          return;
        end
        @(negedge clk);
        w++;
      end
      if (fwd) exp_q.push_back({in_sop, in_eop, in_data});
      taken++;
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
  endtask

  task automatic send_stray(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = 1'b0;
      in_eop   = (k == n - 1);
      in_data  = {8'hEE, 4'(k), 4'd0};
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
  endtask

  task automatic check_stream(input string tag);
    repeat (40) @(negedge clk);
    check({tag, " beat count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        check({tag, " beat"}, {14'd0, got_q[i]}, {14'd0, exp_q[i]});
    got_q.delete();
    exp_q.delete();
    pkt_id++;
  endtask

  initial begin
    int t;
    logic [3:0] types [6] = '{4'd0, 4'd1, 4'd2, 4'd7, 4'd14, 4'd15};
    rst_n = 1'b0; mode = 2'd1; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; out_ready = 1'b0; pend = 1'b0; pend_beat = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);

    // R3 / R4 / R5 sweep over mode, type, length and backpressure pattern
    for (int m = 1; m <= 2; m++)
      for (int ti = 0; ti < 6; ti++)
        for (int len = 1; len <= 3; len++)
          for (int p = 0; p < 3; p++) begin
            bit fwd;
            pat = p;
            mode = 2'(m);
            fwd = (m == 1) || (types[ti] != 4'd0);
            send_pkt(types[ti], len, 0, fwd, -1, 2'd0, 1000, t);
            check_stream(m == 1 ? "R3" : (types[ti] == 4'd0 ? "R4" : "R5"));
          end
    pat = 0;

    // R2: hold mode fills the buffer then stalls, release forwards
    mode = 2'd0;
    send_pkt(4'd0, 6, 0, 1'b1, -1, 2'd0, 8, t);
    check("R2 beats taken while held", t, 4);
    check("R2 no output while held", {31'd0, out_valid}, 32'd0);
    check("R2 nothing captured", got_q.size(), 0);
    check("R2 in_ready low", {31'd0, in_ready}, 32'd0);
    mode = 2'd1;
    send_pkt(4'd0, 6, 4, 1'b1, -1, 2'd0, 1000, t);
    check_stream("R2 release");

    // R2: code 3 also holds, even a control packet; drain mode then forwards it (R5)
    mode = 2'd3;
    send_pkt(4'd15, 5, 0, 1'b1, -1, 2'd0, 8, t);
    check("R2 mode3 beats taken", t, 4);
    check("R2 mode3 no output", got_q.size(), 0);
    mode = 2'd2;
    send_pkt(4'd15, 5, 4, 1'b1, -1, 2'd0, 1000, t);
    check_stream("R2 R5 mode3 release");

    // R6: show -> drain mid packet, next video dropped
    mode = 2'd1;
    send_pkt(4'd0, 6, 0, 1'b1, 3, 2'd2, 1000, t);
    send_pkt(4'd0, 2, 0, 1'b0, -1, 2'd0, 1000, t);
    check_stream("R6 show-to-drain");
    // R6: drain -> show mid packet, next video forwarded
    mode = 2'd2;
    send_pkt(4'd0, 6, 0, 1'b0, 3, 2'd1, 1000, t);
    send_pkt(4'd0, 2, 0, 1'b1, -1, 2'd0, 1000, t);
    check_stream("R6 drain-to-show");
    // R6: show -> hold mid video packet still completes
    mode = 2'd1;
    send_pkt(4'd0, 5, 0, 1'b1, 2, 2'd0, 1000, t);
    check_stream("R6 show-to-hold");

    // R7: non-video packet in drain mode survives a switch to hold
    mode = 2'd2;
    send_pkt(4'd5, 6, 0, 1'b1, 3, 2'd0, 1000, t);
    check_stream("R7");

    // R8: stray beats discarded, following packet passes
    mode = 2'd1;
    send_stray(3);
    send_pkt(4'd2, 2, 0, 1'b1, -1, 2'd0, 1000, t);
    check_stream("R8");

    summary();
    $finish;
  end

endmodule